// File: doc/BRIEF.md
# Word FIFO Transmit Framer with Tail Register

This block sits between a processor-side register write port and a serial infrared frame encoder. Software pushes 32-bit payload words into a small transmit FIFO. The block splits each word into bytes and sends them downstream over a valid/ready byte stream, lowest byte first. Frames whose length is not a multiple of four end with a tail register that holds up to three bytes. The number of valid tail bytes is chosen by which of three tail addresses receives the write, so a single store carries both the data and the count.

A frame ends when the FIFO runs dry after the last queued word. At that point the block sends whatever tail bytes are pending. It then pulses an end-of-data strobe, which tells the encoder to append its check sequence and closing flag, and sets a sticky frame-complete status bit. That bit drives the interrupt line through an enable bit.

A control bit gates the whole path. Clearing it in the middle of a frame drops the frame, and the abort is reported only when a separate report bit is set. Write addresses are 0x00 for FIFO push, 0x04 for control, 0x08 for status (write 1 to clear), and 0x14, 0x18 and 0x1C for the tail.

Top module: `irtx_framer`

## Requirements
- R1: A write to address 0x00 pushes wr_data into the FIFO. Each word leaves as four bytes: bits 7:0 first, then 15:8, then 23:16, then 31:24.
- R2: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_byte holds its value. The stream advances only on a cycle with both high.
- R3: A write to 0x14, 0x18 or 0x1C loads the tail with 1, 2 or 3 valid bytes. The bytes are taken from wr_data starting at bits 7:0, and the unused upper bytes are ignored.
- R4: When the FIFO is empty after the last byte of a word, the pending tail bytes are sent next. The tail count then returns to zero, so the following frame carries no tail unless the tail is written again.
- R5: tx_eod is high for exactly one cycle, in the cycle after the handshake of the frame's last byte, and never while tx_valid is high.
- R6: Control bit 0 (address 0x04) enables transmission. While it is clear, no byte is offered, and FIFO writes are still accepted and sent once the bit is set.
- R7: done_sts is set by the end-of-data pulse and is cleared by writing 1 to bit 0 at address 0x08. irq equals done_sts AND control bit 2.
- R8: With the FIFO empty and no tail loaded, enabling the block produces no byte, no tx_eod and no done_sts.
- R9: Clearing control bit 0 while a word or tail byte is in flight drops the current word and the tail. It sets abort_sts only if control bit 1 is set. abort_sts is cleared by writing 1 to bit 1 at address 0x08.
- R10: After reset, tx_valid, tx_eod, irq, done_sts and abort_sts are 0, the FIFO is empty, the tail is empty and all control bits are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 32 | Register write data |
| tx_byte | output | 8 | Byte offered to the encoder |
| tx_valid | output | 1 | tx_byte is valid |
| tx_ready | input | 1 | Encoder accepts the byte |
| tx_eod | output | 1 | One-cycle end-of-data strobe after the frame's last byte |
| irq | output | 1 | Frame-complete interrupt line |
| done_sts | output | 1 | Sticky frame-complete status |
| abort_sts | output | 1 | Sticky frame-abort status |

## Verification
A wrong byte index or word register shows up at the first handshake after the fault, as a misordered or wrong byte on tx_byte. A tail count that is not cleared shows up one frame later, as extra bytes before tx_eod. A state machine that takes the wrong exit at underrun either omits the tail or never pulses tx_eod. That fault is visible within a few cycles of the last word's final byte, and done_sts and irq stay low.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int unsigned ADR_FIFO  = 32'h00;
  localparam int unsigned ADR_CTRL  = 32'h04;
  localparam int unsigned ADR_STAT  = 32'h08;
  localparam int unsigned ADR_TAIL1 = 32'h14;
  localparam int unsigned ADR_TAIL2 = 32'h18;
  localparam int unsigned ADR_TAIL3 = 32'h1C;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WORD = 2'd1,
    ST_TAIL = 2'd2,
    ST_EOD  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp_q];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wp_n  = do_push ? bump(wp_q) : wp_q;
    rp_n  = do_pop  ? bump(rp_q) : rp_q;
    cnt_n = cnt_q;
    if (do_push && !do_pop) cnt_n = cnt_q + CW'(1);
    if (do_pop && !do_push) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/irtx_regs.sv
module irtx_regs
  import irtx_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          eod_i,
  input  logic          abort_i,
  input  logic          tail_clr_i,
  output logic          push_o,
  output logic          tx_en,
  output logic [23:0]   tail_data,
  output logic [1:0]    tail_cnt,
  output logic          done_sts,
  output logic          abort_sts,
  output logic          irq
);
  logic [2:0]  ctrl_q, ctrl_n;
  logic [23:0] tdat_q, tdat_n;
  logic [1:0]  tcnt_q, tcnt_n;
  logic        done_n, abrt_n;
  logic        sel_ctrl, sel_stat;
  logic [1:0]  tail_sel;

  assign push_o   = wr_en && (wr_addr == AW'(ADR_FIFO));
  assign sel_ctrl = wr_en && (wr_addr == AW'(ADR_CTRL));
  assign sel_stat = wr_en && (wr_addr == AW'(ADR_STAT));

  always_comb begin
    tail_sel = 2'd0;
    if (wr_en && wr_addr == AW'(ADR_TAIL1)) tail_sel = 2'd1;
    if (wr_en && wr_addr == AW'(ADR_TAIL2)) tail_sel = 2'd2;
    if (wr_en && wr_addr == AW'(ADR_TAIL3)) tail_sel = 2'd3;
  end

  always_comb begin
    ctrl_n = sel_ctrl ? wr_data[2:0] : ctrl_q;
    tdat_n = tdat_q;
    tcnt_n = tcnt_q;
    if (tail_clr_i) begin
      tcnt_n = 2'd0;
    end else if (tail_sel != 2'd0) begin
      tdat_n = wr_data[23:0];
      tcnt_n = tail_sel;
    end
    done_n = done_sts;
    if (sel_stat && wr_data[0]) done_n = 1'b0;
    if (eod_i) done_n = 1'b1;
    abrt_n = abort_sts;
    if (sel_stat && wr_data[1]) abrt_n = 1'b0;
    if (abort_i && ctrl_q[1]) abrt_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      tdat_q    <= '0;
      tcnt_q    <= '0;
      done_sts  <= 1'b0;
      abort_sts <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_n;
      tdat_q    <= tdat_n;
      tcnt_q    <= tcnt_n;
      done_sts  <= done_n;
      abort_sts <= abrt_n;
    end
  end

  assign tx_en     = ctrl_q[0];
  assign tail_data = tdat_q;
  assign tail_cnt  = tcnt_q;
  assign irq       = done_sts && ctrl_q[2];

  p_done_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_sts) |-> $past(eod_i));
  p_abort_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_sts) |-> $past(abort_i && ctrl_q[1]));
endmodule

// File: rtl/irtx_ser.sv
module irtx_ser
  import irtx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        fifo_empty,
  input  logic [31:0] fifo_head,
  input  logic [23:0] tail_data,
  input  logic [1:0]  tail_cnt,
  input  logic        tx_ready,
  output logic        fifo_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_valid,
  output logic        tx_eod,
  output logic        tail_clr,
  output logic        abort
);
  tx_state_e   st_q, st_n;
  logic [31:0] word_q, word_n;
  logic [1:0]  idx_q, idx_n;
  logic [31:0] wsh;
  logic [23:0] tsh;

  always_comb begin
    st_n     = st_q;
    word_n   = word_q;
    idx_n    = idx_q;
    fifo_pop = 1'b0;
    tail_clr = 1'b0;
    abort    = 1'b0;
    if (!en && (st_q == ST_WORD || st_q == ST_TAIL)) begin
      abort    = 1'b1;
      tail_clr = 1'b1;
      st_n     = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (en && !fifo_empty) begin
            fifo_pop = 1'b1;
            word_n   = fifo_head;
            idx_n    = 2'd0;
            st_n     = ST_WORD;
          end else if (en && tail_cnt != 2'd0) begin
            idx_n = 2'd0;
            st_n  = ST_TAIL;
          end
        end
        ST_WORD: begin
          if (tx_ready) begin
            if (idx_q != 2'd3) begin
              idx_n = idx_q + 2'd1;
            end else if (!fifo_empty) begin
              fifo_pop = 1'b1;
              word_n   = fifo_head;
              idx_n    = 2'd0;
            end else if (tail_cnt != 2'd0) begin
              idx_n = 2'd0;
              st_n  = ST_TAIL;
            end else begin
              st_n = ST_EOD;
            end
          end
        end
        ST_TAIL: begin
          if (tx_ready) begin
            if (idx_q == tail_cnt - 2'd1) begin
              tail_clr = 1'b1;
              st_n     = ST_EOD;
            end else begin
              idx_n = idx_q + 2'd1;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      word_q <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_n;
      word_q <= word_n;
      idx_q  <= idx_n;
    end
  end

  assign wsh      = word_q >> {idx_q, 3'b000};
  assign tsh      = tail_data >> {idx_q, 3'b000};
  assign tx_byte  = (st_q == ST_TAIL) ? tsh[7:0] : wsh[7:0];
  assign tx_valid = (st_q == ST_WORD) || (st_q == ST_TAIL);
  assign tx_eod   = (st_q == ST_EOD);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && en) |=> (tx_valid && $stable(tx_byte)));
  p_eod_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eod |=> !tx_eod);
  p_eod_novalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eod |-> !tx_valid);
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> !tx_valid);
endmodule

// File: rtl/irtx_framer.sv
module irtx_framer #(
  parameter int AW         = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  output logic [7:0]    tx_byte,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic          tx_eod,
  output logic          irq,
  output logic          done_sts,
  output logic          abort_sts
);
  logic [1:0]  rst_sync;
  logic        rst_s;
  logic        push, pop, f_empty, f_full;
  logic [31:0] f_head;
  logic        tx_en, tail_clr, abort;
  logic [23:0] tail_data;
  logic [1:0]  tail_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  irtx_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .eod_i(tx_eod), .abort_i(abort),
    .tail_clr_i(tail_clr), .push_o(push), .tx_en(tx_en),
    .tail_data(tail_data), .tail_cnt(tail_cnt), .done_sts(done_sts),
    .abort_sts(abort_sts), .irq(irq)
  );

  irtx_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s), .push(push), .push_data(wr_data),
    .pop(pop), .head(f_head), .empty(f_empty), .full(f_full)
  );

  irtx_ser u_ser (
    .clk(clk), .rst_n(rst_s), .en(tx_en), .fifo_empty(f_empty),
    .fifo_head(f_head), .tail_data(tail_data), .tail_cnt(tail_cnt),
    .tx_ready(tx_ready), .fifo_pop(pop), .tx_byte(tx_byte),
    .tx_valid(tx_valid), .tx_eod(tx_eod), .tail_clr(tail_clr),
    .abort(abort)
  );

  p_full_block_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (f_full && push && !pop) |=> f_full);
endmodule

// File: tb/irtx_framer_bench.sv
module irtx_framer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  tx_byte;
  logic        tx_valid, tx_ready, tx_eod, irq, done_sts, abort_sts;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ready_mode = 0;
  logic [7:0] log_b [0:31];
  int nbytes = 0;
  int eod_cnt = 0;
  int eod_pos = -1;

  always #2.5 clk = ~clk;

  irtx_framer u_irtx_framer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_eod(tx_eod), .irq(irq),
    .done_sts(done_sts), .abort_sts(abort_sts)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (ready_mode)
      1: tx_ready = cyc[0];
      2: tx_ready = 1'b0;
      default: tx_ready = 1'b1;
    endcase
  end

  always @(negedge clk) begin
    if (tx_valid && tx_ready && nbytes < 32) begin
      log_b[nbytes] = tx_byte;
      nbytes = nbytes + 1;
    end
    if (tx_eod) begin
      eod_cnt = eod_cnt + 1;
      eod_pos = nbytes;
    end
  end

  always @(negedge clk) begin
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FIFO watchdog FAIL: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_log();
    nbytes = 0; eod_cnt = 0; eod_pos = -1;
  endtask

  task automatic wait_frame();
    for (int i = 0; i < 300 && eod_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 valid", tx_valid, 0);
    check("R10 eod", tx_eod, 0);
    check("R10 irq", irq, 0);
    check("R10 done", done_sts, 0);
    check("R10 abort", abort_sts, 0);
  endtask

  task automatic t_words();
    clr_log();
    wr(8'h00, 32'h44332211);
    wr(8'h00, 32'h88776655);
    repeat (10) @(negedge clk);
    check("R6 no bytes while disabled", nbytes, 0);
    wr(8'h04, 32'h5);
    wait_frame();
    check("R1 byte count", nbytes, 8);
    for (int k = 0; k < 8; k++) check("R1 byte order", log_b[k], 8'h11 * (k + 1));
    check("R5 eod count", eod_cnt, 1);
    check("R5 eod after last byte", eod_pos, 8);
    check("R7 done set", done_sts, 1);
    check("R7 irq asserted", irq, 1);
    wr(8'h08, 32'h1);
    @(negedge clk);
    check("R7 done cleared", done_sts, 0);
    check("R7 irq cleared", irq, 0);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_tail(input int n);
    logic [7:0] a;
    a = (n == 1) ? 8'h14 : (n == 2) ? 8'h18 : 8'h1C;
    clr_log();
    wr(8'h00, 32'hDDCCBBAA);
    wr(a, 32'h99332211);
    wr(8'h04, 32'h1);
    wait_frame();
    check("R3 tail byte count", nbytes, 4 + n);
    check("R1 word first byte", log_b[0], 8'hAA);
    for (int k = 0; k < n; k++) check("R3 tail byte", log_b[4 + k], 8'h11 * (k + 1));
    check("R4 eod after tail", eod_pos, 4 + n);
    wr(8'h08, 32'h1);
    wr(8'h04, 32'h0);
    clr_log();
    wr(8'h00, 32'h04030201);
    wr(8'h04, 32'h1);
    wait_frame();
    check("R4 tail cleared next frame", nbytes, 4);
    check("R4 eod position", eod_pos, 4);
    wr(8'h08, 32'h1);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_backpressure();
    ready_mode = 1;
    clr_log();
    wr(8'h00, 32'h13121110);
    wr(8'h00, 32'h17161514);
    wr(8'h18, 32'h00001918);
    wr(8'h04, 32'h1);
    wait_frame();
    check("R2 count under stall", nbytes, 10);
    for (int k = 0; k < 10; k++) check("R2 order under stall", log_b[k], 8'h10 + k);
    check("R5 eod under stall", eod_pos, 10);
    ready_mode = 0;
    wr(8'h08, 32'h1);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_empty();
    clr_log();
    wr(8'h04, 32'h1);
    repeat (20) @(negedge clk);
    check("R8 no bytes", nbytes, 0);
    check("R8 no eod", eod_cnt, 0);
    check("R8 no done", done_sts, 0);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_abort();
    ready_mode = 2;
    clr_log();
    wr(8'h04, 32'h2);
    wr(8'h00, 32'hA3A2A1A0);
    wr(8'h14, 32'h000000EE);
    wr(8'h04, 32'h3);
    repeat (5) @(negedge clk);
    check("R2 held valid", tx_valid, 1);
    check("R2 held byte", tx_byte, 8'hA0);
    wr(8'h04, 32'h2);
    repeat (3) @(negedge clk);
    check("R9 abort reported", abort_sts, 1);
    check("R9 no done on abort", done_sts, 0);
    wr(8'h08, 32'h2);
    @(negedge clk);
    check("R9 abort cleared", abort_sts, 0);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'hB3B2B1B0);
    wr(8'h04, 32'h1);
    repeat (5) @(negedge clk);
    wr(8'h04, 32'h0);
    repeat (3) @(negedge clk);
    check("R9 abort silent when report off", abort_sts, 0);
    ready_mode = 0;
    clr_log();
    wr(8'h00, 32'hC3C2C1C0);
    wr(8'h04, 32'h1);
    wait_frame();
    check("R9 tail dropped by abort", nbytes, 4);
    check("R9 fresh frame first byte", log_b[0], 8'hC0);
    wr(8'h08, 32'h1);
    wr(8'h04, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; tx_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_words();
    t_tail(1);
    t_tail(2);
    t_tail(3);
    t_backpressure();
    t_empty();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule